// File: doc/BRIEF.md
# Serial Register-Access Slave with Selectable Bit Order

This block lets an external serial host read and write an on-chip register space over a four-wire serial link. A transfer opens when the host pulls chip select low. The first serial bit is a direction flag. Fourteen register address bits follow, then a burst flag, then as many 8-bit data bytes as the host clocks. On the chip side the block drives a plain register bus: an address, write data, a one-cycle write strobe, a one-cycle read strobe, and read data returned by the register file.

The serial clock, chip select and serial input all pass through a synchronizer. They are sampled by a faster system clock, and clock edges are found in the synchronized copy. Three static inputs set the clock polarity, the clock phase and the bit order of the address and data fields. The direction flag always sits in the first position and the burst flag always sits in the sixteenth, whatever the order setting. The serial clock period must be at least 16 system clock periods.

Top module: `spi_regslave`

## Requirements
- R1: The first bit of a frame selects the access type: 1 is a register read and 0 is a register write. Bit 16 is the burst flag. Data bytes start at bit 17.
- R2: With `cfg_msb_first`=0 the address bits arrive as A7 up to A13, then A0 up to A6. Each data byte is carried D0 first.
- R3: With `cfg_msb_first`=1 the address bits arrive as A13 down to A0. Each data byte is carried D7 first.
- R4: With `cfg_cpha`=0, `spi_mosi` is sampled on the first clock edge of each bit. With `cfg_cpha`=1 it is sampled on the second edge. `spi_miso` changes on the other edge. With `cfg_cpol`=1 the idle level of `spi_sck` is high and every edge is inverted.
- R5: A write issues `reg_wr` for exactly one cycle, and only after all 8 bits of a data byte have been received. In that cycle `reg_addr` holds the frame address and `reg_wdata` holds the byte.
- R6: A read pulses `reg_rd` once the burst flag has been sampled, and captures `reg_rdata` in that same cycle. The byte is then sent on `spi_miso`, and `spi_miso_oe` is high while read data is being sent.
- R7: With the burst flag set, the address advances by one after each data byte until chip select rises. With the flag clear, exactly one byte is transferred and any further bits in the frame cause no strobe.
- R8: Raising `spi_csn` aborts the frame. A partly received byte is not written, `spi_miso_oe` falls within SYNC_STAGES+1 cycles, and the next frame starts again at the direction bit.
- R9: `reg_wr` and `reg_rd` are never high in the same cycle, and each strobe lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oversampling) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level; 1 inverts the clock |
| cfg_cpha | input | 1 | 1 moves sampling to the second edge of each bit |
| cfg_msb_first | input | 1 | Bit order of the address and data fields |
| spi_sck | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for spi_miso (high = drive) |
| reg_addr | output | 14 | Register bus address |
| reg_wdata | output | 8 | Register bus write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid in the cycle reg_rd is high |

## Verification
Checks that hold on every cycle cover the strobes: read and write strobes never overlap, and each lasts one cycle. They also check that the output enable falls within a bounded number of cycles once chip select rises. Only directed frames can show the rest: how address and data bits are placed in both orders, which edge samples in all four clock modes, address stepping in bursts, the single-byte limit without burst, and the discarding of a cut-off byte.

// File: rtl/spi_regslave_pkg.sv
`timescale 1ns/1ps
package spi_regslave_pkg;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_FLAG,
        PH_DATA,
        PH_IDLE
    } phase_e;

    // Address bit written by frame slot p of the address field.
    // In swapped-low order the upper half comes first, both halves ascending.
    function automatic int addr_pos(input int p, input logic msb_first, input int aw);
        int lo_bits;
        int hi_bits;
        lo_bits = aw / 2;
        hi_bits = aw - lo_bits;
        if (msb_first)
            return aw - 1 - p;
        else if (p < hi_bits)
            return lo_bits + p;
        else
            return p - hi_bits;
    endfunction

    // Data bit carried by slot k of a data byte.
    function automatic int data_pos(input int k, input logic msb_first, input int dw);
        return msb_first ? (dw - 1 - k) : k;
    endfunction

endpackage

// File: rtl/spi_sync.sv
`timescale 1ns/1ps
module spi_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/spi_edge.sv
`timescale 1ns/1ps
module spi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic cpol,
    input  logic cpha,
    output logic sample,
    output logic shift
);
    logic lvl_d, lvl_q;
    logic lead, trail;

    always_comb begin
        lvl_d = sck_s ^ cpol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end

    assign lead   = lvl_d & ~lvl_q;
    assign trail  = ~lvl_d & lvl_q;
    assign sample = cpha ? trail : lead;
    assign shift  = cpha ? lead : trail;
endmodule

// File: rtl/spi_regslave_core.sv
`timescale 1ns/1ps
module spi_regslave_core
    import spi_regslave_pkg::*;
#(
    parameter int AW = 14,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_act,
    input  logic          sample,
    input  logic          shift,
    input  logic          mosi,
    input  logic          msb_first,
    input  logic [DW-1:0] reg_rdata,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_wr,
    output logic          reg_rd,
    output logic          miso,
    output logic          miso_oe
);
    localparam int ACNT_W = $clog2(AW);
    localparam int DCNT_W = (DW > 2) ? $clog2(DW) : 1;
    localparam logic [ACNT_W-1:0] ALAST = ACNT_W'(AW - 1);
    localparam logic [DCNT_W-1:0] DLAST = DCNT_W'(DW - 1);

    typedef struct packed {
        phase_e            phase;
        logic [ACNT_W-1:0] acnt;
        logic [DCNT_W-1:0] rcnt;
        logic [DCNT_W-1:0] tcnt;
        logic              rw;
        logic              burst;
        logic [AW-1:0]     addr;
        logic [DW-1:0]     rx;
        logic [DW-1:0]     tx;
        logic [DW-1:0]     wdata;
        logic              wr;
        logic              rd;
        logic              inc;
        logic              miso;
    } st_t;

    st_t st_d, st_q;
    logic [DW-1:0] rx_new;

    always_comb begin
        st_d      = st_q;
        st_d.wr   = 1'b0;
        st_d.rd   = 1'b0;
        st_d.inc  = 1'b0;
        rx_new    = st_q.rx;
        rx_new[data_pos(int'(st_q.rcnt), msb_first, DW)] = mosi;

        if (st_q.rd)                 st_d.tx   = reg_rdata;
        if (st_q.wr && st_q.burst)   st_d.addr = st_q.addr + 1'b1;
        if (st_q.inc) begin
            st_d.addr = st_q.addr + 1'b1;
            st_d.rd   = 1'b1;
        end

        if (!cs_act) begin
            st_d.phase = PH_CMD;
            st_d.acnt  = '0;
            st_d.rcnt  = '0;
            st_d.tcnt  = '0;
            st_d.miso  = 1'b0;
            st_d.rd    = 1'b0;
            st_d.inc   = 1'b0;
        end else begin
            if (sample) begin
                case (st_q.phase)
                    PH_CMD: begin
                        st_d.rw    = mosi;
                        st_d.acnt  = '0;
                        st_d.phase = PH_ADDR;
                    end
                    PH_ADDR: begin
                        st_d.addr[addr_pos(int'(st_q.acnt), msb_first, AW)] = mosi;
                        st_d.acnt = st_q.acnt + 1'b1;
                        if (st_q.acnt == ALAST) st_d.phase = PH_FLAG;
                    end
                    PH_FLAG: begin
                        st_d.burst = mosi;
                        st_d.rcnt  = '0;
                        st_d.tcnt  = '0;
                        st_d.phase = PH_DATA;
                        if (st_q.rw) st_d.rd = 1'b1;
                    end
                    PH_DATA: begin
                        st_d.rx   = rx_new;
                        st_d.rcnt = st_q.rcnt + 1'b1;
                        if (st_q.rcnt == DLAST) begin
                            st_d.rcnt = '0;
                            if (!st_q.rw) begin
                                st_d.wr    = 1'b1;
                                st_d.wdata = rx_new;
                            end else if (st_q.burst) begin
                                st_d.inc = 1'b1;
                            end
                            if (!st_q.burst) st_d.phase = PH_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
            if (shift && st_q.phase == PH_DATA && st_q.rw) begin
                st_d.miso = st_q.tx[data_pos(int'(st_q.tcnt), msb_first, DW)];
                st_d.tcnt = (st_q.tcnt == DLAST) ? '0 : st_q.tcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_CMD, default: '0};
        else        st_q <= st_d;
    end

    assign reg_addr  = st_q.addr;
    assign reg_wdata = st_q.wdata;
    assign reg_wr    = st_q.wr;
    assign reg_rd    = st_q.rd;
    assign miso      = st_q.miso;
    assign miso_oe   = cs_act & st_q.rw & (st_q.phase == PH_DATA);
endmodule

// File: rtl/spi_regslave.sv
`timescale 1ns/1ps
module spi_regslave #(
    parameter int AW          = 14,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_cpol,
    input  logic          cfg_cpha,
    input  logic          cfg_msb_first,
    input  logic          spi_sck,
    input  logic          spi_csn,
    input  logic          spi_mosi,
    output logic          spi_miso,
    output logic          spi_miso_oe,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_wr,
    output logic          reg_rd,
    input  logic [DW-1:0] reg_rdata
);
    logic [2:0] pins_s;
    logic       sample, shift;

    spi_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_sck, spi_csn, spi_mosi}),
        .dout  (pins_s)
    );

    spi_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_s  (pins_s[2]),
        .cpol   (cfg_cpol),
        .cpha   (cfg_cpha),
        .sample (sample),
        .shift  (shift)
    );

    spi_regslave_core #(
        .AW (AW),
        .DW (DW)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (~pins_s[1]),
        .sample    (sample),
        .shift     (shift),
        .mosi      (pins_s[0]),
        .msb_first (cfg_msb_first),
        .reg_rdata (reg_rdata),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .miso      (spi_miso),
        .miso_oe   (spi_miso_oe)
    );
endmodule

// File: rtl/spi_regslave_chk.sv
`timescale 1ns/1ps
module spi_regslave_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic spi_csn,
    input logic spi_miso_oe,
    input logic reg_wr,
    input logic reg_rd
);
    logic [7:0] hi_cnt_d, hi_cnt_q;

    always_comb begin
        hi_cnt_d = hi_cnt_q;
        if (!spi_csn)              hi_cnt_d = '0;
        else if (hi_cnt_q != 8'hFF) hi_cnt_d = hi_cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_cnt_q <= '0;
        else        hi_cnt_q <= hi_cnt_d;
    end

    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    p_wr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    p_rd_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    p_oe_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_csn && hi_cnt_q >= 8'(SYNC_STAGES + 1)) |-> !spi_miso_oe);
endmodule

bind spi_regslave spi_regslave_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_csn     (spi_csn),
    .spi_miso_oe (spi_miso_oe),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd)
);

// File: tb/spi_regslave_tb.sv
`timescale 1ns/1ps
module spi_regslave_tb;
    localparam real HALF = 40.0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_msb_first = 1'b0;
    logic spi_sck = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
    logic spi_miso, spi_miso_oe;
    logic [13:0] reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;
    logic reg_wr, reg_rd;

    int checks = 0, fails = 0;
    int wn = 0, rn = 0, both = 0;
    logic [13:0] wlog_a [16];
    logic [7:0]  wlog_d [16];
    logic [7:0]  txb [4];
    logic [7:0]  rxb [4];
    logic        oe_mid;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] rmodel(input logic [13:0] a);
        return a[7:0] ^ {2'b00, a[13:8]} ^ 8'hA5;
    endfunction

    assign reg_rdata = rmodel(reg_addr);

    spi_regslave u_dut (
        .clk (clk), .rst_n (rst_n),
        .cfg_cpol (cfg_cpol), .cfg_cpha (cfg_cpha), .cfg_msb_first (cfg_msb_first),
        .spi_sck (spi_sck), .spi_csn (spi_csn), .spi_mosi (spi_mosi),
        .spi_miso (spi_miso), .spi_miso_oe (spi_miso_oe),
        .reg_addr (reg_addr), .reg_wdata (reg_wdata),
        .reg_wr (reg_wr), .reg_rd (reg_rd), .reg_rdata (reg_rdata)
    );

    always @(posedge clk) begin
        if (reg_wr) begin
            if (wn < 16) begin
                wlog_a[wn] = reg_addr;
                wlog_d[wn] = reg_wdata;
            end
            wn++;
        end
        if (reg_rd) rn++;
        if (reg_wr && reg_rd) both++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Host model: frame bits are built from the requirement text.
    task automatic run_frame(input logic pol, input logic pha, input logic msb,
                             input logic rw, input logic [13:0] a, input logic bst,
                             input int nby, input int stop_bits);
        int total;
        cfg_cpol = pol; cfg_cpha = pha; cfg_msb_first = msb;
        spi_sck = pol; oe_mid = 1'b0;
        for (int j = 0; j < 4; j++) rxb[j] = 8'h00;
        repeat (6) @(posedge clk);
        #1;
        spi_csn = 1'b0;
        #(HALF);
        total = 16 + 8 * nby;
        for (int i = 0; i < total; i++) begin
            logic b, r;
            int k, by, ap;
            k = 0; by = 0;
            if (i == 0) b = rw;
            else if (i <= 14) begin
                ap = msb ? (13 - (i - 1)) : ((i - 1) < 7 ? (i - 1) + 7 : (i - 1) - 7);
                b = a[ap];
            end else if (i == 15) b = bst;
            else begin
                k = (i - 16) % 8; by = (i - 16) / 8;
                b = txb[by][msb ? 7 - k : k];
            end
            if (!pha) begin
                spi_mosi = b; #(HALF);
                spi_sck = ~pol; r = spi_miso;
                if (i >= 16 && spi_miso_oe) oe_mid = 1'b1;
                #(HALF); spi_sck = pol;
            end else begin
                spi_sck = ~pol; spi_mosi = b; #(HALF);
                spi_sck = pol; r = spi_miso;
                if (i >= 16 && spi_miso_oe) oe_mid = 1'b1;
                #(HALF);
            end
            if (i >= 16) rxb[by][msb ? 7 - k : k] = r;
            if (stop_bits >= 0 && i + 1 == stop_bits) break;
        end
        #(HALF);
        spi_csn = 1'b1;
        repeat (6) @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        chk(spi_miso_oe == 1'b0, "R8 reset oe", int'(spi_miso_oe), 0);
        chk(reg_wr == 1'b0 && reg_rd == 1'b0, "R9 reset strobes", int'({reg_wr, reg_rd}), 0);
    endtask

    task automatic t_write_lsb_mode0;
        int w0 = wn;
        txb[0] = 8'h3C;
        run_frame(0, 0, 0, 0, 14'h2A51, 0, 1, -1);
        chk(wn == w0 + 1, "R1 R5 one write", wn - w0, 1);
        chk(wlog_a[w0] == 14'h2A51, "R2 addr lsb order", int'(wlog_a[w0]), 'h2A51);
        chk(wlog_d[w0] == 8'h3C, "R2 data D0 first", int'(wlog_d[w0]), 'h3C);
    endtask

    task automatic t_write_msb_mode3;
        int w0 = wn;
        txb[0] = 8'hB1;
        run_frame(1, 1, 1, 0, 14'h1357, 0, 1, -1);
        chk(wlog_a[w0] == 14'h1357, "R3 R4 addr msb mode3", int'(wlog_a[w0]), 'h1357);
        chk(wlog_d[w0] == 8'hB1, "R3 R4 data msb mode3", int'(wlog_d[w0]), 'hB1);
    endtask

    task automatic t_read_lsb_mode1;
        int r0 = rn;
        txb[0] = 8'h00;
        run_frame(0, 1, 0, 1, 14'h0C4E, 0, 2, -1);
        chk(rxb[0] == rmodel(14'h0C4E), "R6 R4 read mode1", int'(rxb[0]), int'(rmodel(14'h0C4E)));
        chk(oe_mid == 1'b1, "R6 oe during read", int'(oe_mid), 1);
        chk(rn == r0 + 1, "R7 single read no burst", rn - r0, 1);
    endtask

    task automatic t_read_burst_msb_mode2;
        for (int j = 0; j < 3; j++) txb[j] = 8'h00;
        run_frame(1, 0, 1, 1, 14'h3FFE, 1, 3, -1);
        chk(rxb[0] == rmodel(14'h3FFE), "R7 R3 burst byte0", int'(rxb[0]), int'(rmodel(14'h3FFE)));
        chk(rxb[1] == rmodel(14'h3FFF), "R7 burst byte1", int'(rxb[1]), int'(rmodel(14'h3FFF)));
        chk(rxb[2] == rmodel(14'h0000), "R7 burst byte2 wrap", int'(rxb[2]), int'(rmodel(14'h0000)));
    endtask

    task automatic t_write_burst;
        int w0 = wn;
        txb[0] = 8'h11; txb[1] = 8'hE7;
        run_frame(0, 0, 0, 0, 14'h0100, 1, 2, -1);
        chk(wn == w0 + 2, "R7 burst write count", wn - w0, 2);
        chk(wlog_a[w0 + 1] == 14'h0101, "R7 burst addr step", int'(wlog_a[w0 + 1]), 'h0101);
        chk(wlog_d[w0 + 1] == 8'hE7, "R7 burst data", int'(wlog_d[w0 + 1]), 'hE7);
    endtask

    task automatic t_write_no_burst_extra;
        int w0 = wn;
        txb[0] = 8'h5A; txb[1] = 8'h99;
        run_frame(0, 0, 1, 0, 14'h0222, 0, 2, -1);
        chk(wn == w0 + 1, "R7 extra byte ignored", wn - w0, 1);
        chk(wlog_d[w0] == 8'h5A, "R7 first byte kept", int'(wlog_d[w0]), 'h5A);
    endtask

    task automatic t_abort;
        int w0 = wn;
        txb[0] = 8'hFF;
        run_frame(0, 1, 0, 0, 14'h0777, 0, 1, 16 + 5);
        chk(wn == w0, "R8 partial byte dropped", wn - w0, 0);
        run_frame(0, 0, 0, 1, 14'h0042, 0, 1, 16 + 3);
        chk(oe_mid == 1'b1, "R8 oe before abort", int'(oe_mid), 1);
        chk(spi_miso_oe == 1'b0, "R8 oe released", int'(spi_miso_oe), 0);
        txb[0] = 8'h6D;
        run_frame(0, 0, 0, 0, 14'h0456, 0, 1, -1);
        chk(wn == w0 + 1 && wlog_a[w0] == 14'h0456, "R8 restart after abort",
            int'(wlog_a[w0]), 'h0456);
    endtask

    initial begin
        #(1000000.0);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        t_write_lsb_mode0();
        t_write_msb_mode3();
        t_read_lsb_mode1();
        t_read_burst_msb_mode2();
        t_write_burst();
        t_write_no_burst_extra();
        t_abort();
        chk(both == 0, "R9 strobes never overlap", both, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule